// File: doc/BRIEF.md
# Pseudo-SRAM Serial/Quad Command Responder

This block is the device side of a serial pseudo-SRAM link. It is meant to sit in a verification or emulation environment in place of a real memory, so that a host-side memory engine can be exercised against it. The block watches a chip-select, a serial clock and four data lines. It decodes each command and keeps three pieces of mode state: the lane width (one lane or four), an armed flag for the two-step software reset, and the burst wrap length, which is either 1024 or 32 bytes. Reads and writes go to a small internal byte array whose size is set by a parameter. Burst addresses wrap inside the aligned block of the current wrap length. An identification read returns a maker byte and a die-status byte.

The serial clock is oversampled by the system clock `clk`. Inputs are sampled on each detected rising edge of `sck`. Read data is launched on each detected falling edge, so the host samples it on the following rising edge. Raising chip-select at any point ends the current command and readies the decoder for a fresh opcode.

Top module: `psram_cmd_front`

## Requirements
- R1: After reset the block is in one-lane mode, the wrap length is 1024 bytes (`wrap_short`=0) and `sio_oe` is 0.
- R2: In one-lane mode an opcode arrives MSB first on `sio_in[0]` over 8 clocks. In four-lane mode it arrives as two nibbles, high nibble first, on `sio_in[3:0]`. Opcode 0x35 (legal only in one-lane mode) sets `quad_mode`. Opcode 0xF5 (legal only in four-lane mode) clears it.
- R3: A reset takes effect only when opcode 0x99 is the next completed command after 0x66. Any other completed command in between, legal or not, disarms it.
- R4: A completed reset sets one-lane mode and a wrap length of 1024 bytes.
- R5: Each 0xC0, in either mode, toggles `wrap_short` (0 = 1024 bytes, 1 = 32 bytes).
- R6: The address is 24 bits, sent MSB first: 24 one-lane clocks, or 6 four-lane clocks, high nibble first. Its low bits index the array. Data bytes are sent MSB first. One-lane read data is driven on `sio_out[1]` with `sio_oe`=4'b0010. Four-lane read data is driven on all lanes with `sio_oe`=4'b1111. Both change after a falling edge of `sck`.
- R7: Reads in one-lane mode: 0x03 uses one-lane address and data with no wait clocks; 0x0B is the same with 8 wait clocks; 0xEB uses four-lane address and data with 6 wait clocks. Reads in four-lane mode: 0x0B with 4 wait clocks and 0xEB with 6 wait clocks, all four-lane.
- R8: Writes in one-lane mode: 0x02 is one-lane throughout; 0x38 uses four-lane address and data. In four-lane mode both 0x02 and 0x38 are four-lane. Each completed data byte is stored.
- R9: After each data byte, the address advances by one and wraps inside the aligned block of the current wrap length. Bits above the block stay unchanged.
- R10: Opcode 0x9F, legal only in one-lane mode, takes an address and no wait clocks. It then returns, on one lane, the maker byte (default 0x0D) and the die-status byte (0x5D for a passing die, 0x55 for a failing one), alternating.
- R11: Raising `ce_n` ends any command. A partly received write byte is discarded, and `sio_oe` returns to 0 one clock later.
- R12: An opcode that is unknown or illegal in the current mode (for example 0x9F or 0x03 in four-lane mode, or 0xAA) is ignored. Nothing is driven and no mode changes until `ce_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the link |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial link clock from the host |
| sio_in | input | 4 | Data lanes as driven by the host |
| sio_out | output | 4 | Data lanes as driven by the block |
| sio_oe | output | 4 | Per-lane output enable |
| quad_mode | output | 1 | 1 when commands are taken on four lanes |
| wrap_short | output | 1 | 1 when bursts wrap at 32 bytes, 0 at 1024 |

## Verification
The array path is exercised with every read and write opcode in both lane modes. Each written pattern is read back with a different command, which separates lane-width, wait-count and nibble-order faults. Bursts that start near the end of a 1024-byte block and of a 32-byte block distinguish wrapping at the right boundary from plain incrementing. Reset sequences with a 0xC0 slipped between 0x66 and 0x99, and with nothing slipped between them, separate correct disarming from a reset that fires regardless. Illegal opcodes in each mode and a chip-select raised in the middle of a byte show that nothing is driven or stored when it should not be.

// File: rtl/psram_dec_pkg.sv
package psram_dec_pkg;

    localparam int ADDR_W   = 24;
    localparam int LONG_LG  = 10;
    localparam int SHORT_LG = 5;

    typedef enum logic [2:0] {
        P_CMD, P_ADDR, P_WAIT, P_RD, P_WR, P_HALT
    } phase_e;

    typedef enum logic [2:0] {
        A_ACCESS, A_QON, A_QOFF, A_RSTEN, A_RST, A_WRAP, A_BAD
    } act_e;

    typedef struct packed {
        act_e       act;
        logic       rd;
        logic       id;
        logic       aq;
        logic       dq;
        logic [3:0] wt;
    } cmd_t;

    function automatic cmd_t decode_op(input logic [7:0] op, input logic quad);
        cmd_t c;
        c.act = A_BAD;
        c.rd  = 1'b0;
        c.id  = 1'b0;
        c.aq  = 1'b0;
        c.dq  = 1'b0;
        c.wt  = 4'd0;
        if (!quad) begin
            case (op)
                8'h03: begin c.act = A_ACCESS; c.rd = 1'b1; end
                8'h0B: begin c.act = A_ACCESS; c.rd = 1'b1; c.wt = 4'd8; end
                8'hEB: begin c.act = A_ACCESS; c.rd = 1'b1; c.aq = 1'b1; c.dq = 1'b1; c.wt = 4'd6; end
                8'h02: begin c.act = A_ACCESS; end
                8'h38: begin c.act = A_ACCESS; c.aq = 1'b1; c.dq = 1'b1; end
                8'h9F: begin c.act = A_ACCESS; c.rd = 1'b1; c.id = 1'b1; end
                8'h35: c.act = A_QON;
                8'h66: c.act = A_RSTEN;
                8'h99: c.act = A_RST;
                8'hC0: c.act = A_WRAP;
                default: c.act = A_BAD;
            endcase
        end else begin
            case (op)
                8'h0B: begin c.act = A_ACCESS; c.rd = 1'b1; c.aq = 1'b1; c.dq = 1'b1; c.wt = 4'd4; end
                8'hEB: begin c.act = A_ACCESS; c.rd = 1'b1; c.aq = 1'b1; c.dq = 1'b1; c.wt = 4'd6; end
                8'h02, 8'h38: begin c.act = A_ACCESS; c.aq = 1'b1; c.dq = 1'b1; end
                8'hF5: c.act = A_QOFF;
                8'h66: c.act = A_RSTEN;
                8'h99: c.act = A_RST;
                8'hC0: c.act = A_WRAP;
                default: c.act = A_BAD;
            endcase
        end
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] wrap_inc(input logic [ADDR_W-1:0] a, input logic short_wrap);
        logic [ADDR_W-1:0] r;
        r = a;
        if (short_wrap) r[SHORT_LG-1:0] = a[SHORT_LG-1:0] + 1'b1;
        else            r[LONG_LG-1:0]  = a[LONG_LG-1:0] + 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/psd_mode_ctrl.sv
module psd_mode_ctrl
    import psram_dec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_done,
    input  act_e act,
    output logic quad,
    output logic wrap_short
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            quad       <= 1'b0;
            wrap_short <= 1'b0;
            armed      <= 1'b0;
        end else if (cmd_done) begin
            armed <= (act == A_RSTEN);
            case (act)
                A_QON:  quad <= 1'b1;
                A_QOFF: quad <= 1'b0;
                A_WRAP: wrap_short <= ~wrap_short;
                A_RST: begin
                    if (armed) begin
                        quad       <= 1'b0;
                        wrap_short <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: an unarmed reset opcode changes nothing
    p_unarmed_reset_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && act == A_RST && !armed) |=> ($stable(quad) && $stable(wrap_short)));

    // R3: any other completed command disarms
    p_disarm_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && act != A_RSTEN) |=> !armed);

    // R4: armed reset lands in one-lane, long wrap
    p_reset_state_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && act == A_RST && armed) |=> (!quad && !wrap_short));

    // R5: each wrap opcode flips the length
    p_wrap_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && act == A_WRAP) |=> (wrap_short != $past(wrap_short)));

    // R2: lane mode moves only on a completed command
    p_quad_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cmd_done |=> $stable(quad));

endmodule

// File: rtl/psd_addr_gen.sv
module psd_addr_gen
    import psram_dec_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              adv,
    input  logic              wrap_short,
    output logic [IDX_W-1:0]  idx
);

    logic [ADDR_W-1:0] addr;

    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= load_addr;
        else if (adv)  addr <= wrap_inc(addr, wrap_short);
    end

    assign idx = addr[IDX_W-1:0];

    // R9: advancing never leaves the aligned 1024-byte block
    p_wrap_block_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (addr[ADDR_W-1:LONG_LG] == $past(addr[ADDR_W-1:LONG_LG])));

    // R9: in short mode the bits above the 32-byte block also hold
    p_wrap_short_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && wrap_short) |=> (addr[ADDR_W-1:SHORT_LG] == $past(addr[ADDR_W-1:SHORT_LG])));

endmodule

// File: rtl/psd_array.sv
module psd_array #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/psram_cmd_front.sv
module psram_cmd_front
    import psram_dec_pkg::*;
#(
    parameter int         ARRAY_LG = 11,
    parameter logic [7:0] MAKER_ID = 8'h0D,
    parameter bit         DIE_PASS = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       sck,
    input  logic [3:0] sio_in,
    output logic [3:0] sio_out,
    output logic [3:0] sio_oe,
    output logic       quad_mode,
    output logic       wrap_short
);

    localparam logic [7:0] DIE_BYTE = DIE_PASS ? 8'h5D : 8'h55;

    phase_e            phase;
    cmd_t              info;
    logic              sck_q;
    logic [4:0]        cnt;
    logic [2:0]        pos;
    logic [7:0]        sh;
    logic [7:0]        obuf;
    logic [ADDR_W-1:0] addr_sh;
    logic              id_idx;

    logic              rise, fall, lq;
    logic [7:0]        sh_nx;
    logic [ADDR_W-1:0] addr_nx;
    logic [4:0]        addr_last;
    logic [2:0]        byte_last;
    cmd_t              dec;
    logic              cmd_done, addr_load, rd_adv, wr_en;
    logic [7:0]        rd_data, src;
    logic [ARRAY_LG-1:0] idx;

    assign rise = sck & ~sck_q & ~ce_n;
    assign fall = ~sck & sck_q & ~ce_n;

    always_comb begin
        case (phase)
            P_CMD:       lq = quad_mode;
            P_ADDR:      lq = info.aq;
            P_RD, P_WR:  lq = info.dq;
            default:     lq = 1'b0;
        endcase
    end

    assign sh_nx     = lq ? {sh[3:0], sio_in} : {sh[6:0], sio_in[0]};
    assign addr_nx   = lq ? {addr_sh[ADDR_W-5:0], sio_in} : {addr_sh[ADDR_W-2:0], sio_in[0]};
    assign addr_last = info.aq ? 5'd5 : 5'd23;
    assign byte_last = lq ? 3'd1 : 3'd7;
    assign dec       = decode_op(sh_nx, quad_mode);

    assign cmd_done  = (phase == P_CMD) && rise && (cnt == (quad_mode ? 5'd1 : 5'd7));
    assign addr_load = (phase == P_ADDR) && rise && (cnt == addr_last);
    assign rd_adv    = (phase == P_RD) && fall && (pos == 3'd0) && !info.id;
    assign wr_en     = (phase == P_WR) && rise && (pos == byte_last);

    assign src = (pos != 3'd0) ? obuf : (info.id ? (id_idx ? DIE_BYTE : MAKER_ID) : rd_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= P_CMD;
            info    <= '{act: A_BAD, rd: 1'b0, id: 1'b0, aq: 1'b0, dq: 1'b0, wt: 4'd0};
            sck_q   <= 1'b0;
            cnt     <= '0;
            pos     <= '0;
            sh      <= '0;
            obuf    <= '0;
            addr_sh <= '0;
            id_idx  <= 1'b0;
            sio_out <= '0;
            sio_oe  <= '0;
        end else begin
            sck_q <= sck;
            if (ce_n) begin
                phase   <= P_CMD;
                cnt     <= '0;
                pos     <= '0;
                sh      <= '0;
                id_idx  <= 1'b0;
                sio_out <= '0;
                sio_oe  <= '0;
            end else begin
                case (phase)
                    P_CMD: if (rise) begin
                        sh  <= sh_nx;
                        cnt <= cnt + 5'd1;
                        if (cmd_done) begin
                            cnt   <= '0;
                            info  <= dec;
                            phase <= (dec.act == A_ACCESS) ? P_ADDR : P_HALT;
                        end
                    end
                    P_ADDR: if (rise) begin
                        addr_sh <= addr_nx;
                        cnt     <= cnt + 5'd1;
                        if (addr_load) begin
                            cnt <= '0;
                            if (info.wt != 4'd0) phase <= P_WAIT;
                            else                 phase <= info.rd ? P_RD : P_WR;
                        end
                    end
                    P_WAIT: if (rise) begin
                        cnt <= cnt + 5'd1;
                        if (cnt == ({1'b0, info.wt} - 5'd1)) begin
                            cnt   <= '0;
                            phase <= P_RD;
                        end
                    end
                    P_RD: if (fall) begin
                        if (info.dq) begin
                            sio_out <= src[7:4];
                            obuf    <= {src[3:0], 4'b0000};
                            sio_oe  <= 4'b1111;
                        end else begin
                            sio_out <= {2'b00, src[7], 1'b0};
                            obuf    <= {src[6:0], 1'b0};
                            sio_oe  <= 4'b0010;
                        end
                        pos <= (pos == byte_last) ? 3'd0 : pos + 3'd1;
                        if (pos == 3'd0 && info.id) id_idx <= ~id_idx;
                    end
                    P_WR: if (rise) begin
                        sh  <= sh_nx;
                        pos <= (pos == byte_last) ? 3'd0 : pos + 3'd1;
                    end
                    default: ;
                endcase
            end
        end
    end

    psd_mode_ctrl u_mode (
        .clk        (clk),
        .rst        (rst),
        .cmd_done   (cmd_done),
        .act        (dec.act),
        .quad       (quad_mode),
        .wrap_short (wrap_short)
    );

    psd_addr_gen #(.IDX_W(ARRAY_LG)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (addr_load),
        .load_addr  (addr_nx),
        .adv        (rd_adv | wr_en),
        .wrap_short (wrap_short),
        .idx        (idx)
    );

    psd_array #(.IDX_W(ARRAY_LG)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .widx  (idx),
        .wdata (sh_nx),
        .ridx  (idx),
        .rdata (rd_data)
    );

    // R11: chip-select high releases the lanes on the next clock
    p_release_r11: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (sio_oe == 4'b0000));

    // R6: lane enables take only the one-lane or four-lane shape
    p_lane_shape_r6: assert property (@(posedge clk) disable iff (rst)
        (sio_oe == 4'b0000) || (sio_oe == 4'b0010) || (sio_oe == 4'b1111));

    // R12: an ignored command keeps the lanes undriven
    p_halt_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (phase == P_HALT) |-> (sio_oe == 4'b0000));

    // R7: only array or ID accesses reach the address phase
    p_access_only_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == P_ADDR) |-> (info.act == A_ACCESS));

endmodule

// File: tb/psram_cmd_front_tb.sv
module psram_cmd_front_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       ce_n;
    logic       sck;
    logic [3:0] sio_in;
    logic [3:0] sio_out;
    logic [3:0] sio_oe;
    logic       quad_mode;
    logic       wrap_short;

    always #10 clk = ~clk;

    psram_cmd_front u_dut (
        .clk        (clk),
        .rst        (rst),
        .ce_n       (ce_n),
        .sck        (sck),
        .sio_in     (sio_in),
        .sio_out    (sio_out),
        .sio_oe     (sio_oe),
        .quad_mode  (quad_mode),
        .wrap_short (wrap_short)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] m_mem [2048];
    bit m_quad = 1'b0;
    bit m_wrap = 1'b0;
    bit m_arm  = 1'b0;

    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pairs design bytes with predicted ones
    logic [7:0] mon_a, mon_e;
    string      mon_t;
    always @(negedge clk) begin
        if (act_q.size() != 0 && exp_q.size() != 0) begin
            mon_a = act_q.pop_front();
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            chk(mon_a == mon_e, mon_t, {24'd0, mon_a}, {24'd0, mon_e});
        end
    end

    function automatic logic [23:0] wnext(input logic [23:0] a, input bit s);
        if (s) return {a[23:5], a[4:0] + 5'd1};
        return {a[23:10], a[9:0] + 10'd1};
    endfunction

    // reference model of the mode rules (R2..R5)
    task automatic model_cmd(input logic [7:0] op);
        bit na;
        na = 1'b0;
        if (!m_quad) begin
            case (op)
                8'h35: m_quad = 1'b1;
                8'h66: na = 1'b1;
                8'h99: if (m_arm) begin m_quad = 1'b0; m_wrap = 1'b0; end
                8'hC0: m_wrap = ~m_wrap;
                default: ;
            endcase
        end else begin
            case (op)
                8'hF5: m_quad = 1'b0;
                8'h66: na = 1'b1;
                8'h99: if (m_arm) begin m_quad = 1'b0; m_wrap = 1'b0; end
                8'hC0: m_wrap = ~m_wrap;
                default: ;
            endcase
        end
        m_arm = na;
    endtask

    task automatic step(input logic [3:0] d, output logic [3:0] o, output logic [3:0] e);
        @(negedge clk);
        sck = 1'b0;
        sio_in = d;
        @(negedge clk);
        @(negedge clk);
        o = sio_out;
        e = sio_oe;
        sck = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit q);
        logic [3:0] o, e;
        if (q) begin
            step(b[7:4], o, e);
            step(b[3:0], o, e);
        end else begin
            for (int i = 7; i >= 0; i--) step({3'b000, b[i]}, o, e);
        end
    endtask

    task automatic send_addr(input logic [23:0] a, input bit q);
        logic [3:0] o, e;
        if (q) for (int i = 5; i >= 0; i--) step(a[i*4 +: 4], o, e);
        else   for (int i = 23; i >= 0; i--) step({3'b000, a[i]}, o, e);
    endtask

    task automatic dummy(input int n);
        logic [3:0] o, e;
        for (int i = 0; i < n; i++) step(4'h0, o, e);
    endtask

    task automatic recv_byte(input bit q, output logic [7:0] b, inout bit ok);
        logic [3:0] o, e;
        b = 8'h00;
        if (q) begin
            for (int i = 0; i < 2; i++) begin
                step(4'h0, o, e);
                b = {b[3:0], o};
                if (e != 4'b1111) ok = 1'b0;
            end
        end else begin
            for (int i = 0; i < 8; i++) begin
                step(4'h0, o, e);
                b = {b[6:0], o[1]};
                if (e != 4'b0010) ok = 1'b0;
            end
        end
    endtask

    task automatic cs_begin;
        @(negedge clk);
        ce_n = 1'b0;
    endtask

    task automatic cs_end;
        @(negedge clk);
        sck = 1'b0;
        @(negedge clk);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic simple_cmd(input logic [7:0] op);
        cs_begin();
        send_byte(op, m_quad);
        model_cmd(op);
        cs_end();
    endtask

    task automatic do_write(input logic [7:0] op, input bit aq, input bit dq,
                            input logic [23:0] addr, input int n, input logic [31:0] data);
        logic [23:0] a;
        logic [7:0]  b;
        cs_begin();
        send_byte(op, m_quad);
        model_cmd(op);
        send_addr(addr, aq);
        a = addr;
        for (int k = 0; k < n; k++) begin
            b = data[31-8*k -: 8];
            send_byte(b, dq);
            m_mem[a[10:0]] = b;
            a = wnext(a, m_wrap);
        end
        cs_end();
    endtask

    task automatic do_read(input logic [7:0] op, input bit aq, input bit dq, input int wt,
                           input logic [23:0] addr, input int n, input string tag);
        logic [23:0] a;
        logic [7:0]  b;
        bit ok;
        ok = 1'b1;
        cs_begin();
        send_byte(op, m_quad);
        model_cmd(op);
        send_addr(addr, aq);
        dummy(wt);
        a = addr;
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(m_mem[a[10:0]]);
            tag_q.push_back(tag);
            recv_byte(dq, b, ok);
            act_q.push_back(b);
            a = wnext(a, m_wrap);
        end
        cs_end();
        chk(ok, "R6 lane enables during read", {31'd0, ok}, 32'd1);
    endtask

    task automatic quiet_cmd(input logic [7:0] op, input string tag);
        logic [3:0] o, e;
        bit quiet;
        quiet = 1'b1;
        cs_begin();
        send_byte(op, m_quad);
        model_cmd(op);
        for (int i = 0; i < 16; i++) begin
            step(4'h0, o, e);
            if (e != 4'b0000) quiet = 1'b0;
        end
        cs_end();
        chk(quiet, tag, {31'd0, quiet}, 32'd1);
    endtask

    task automatic chk_mode(input string tag);
        chk(quad_mode == m_quad, {tag, " quad_mode"}, {31'd0, quad_mode}, {31'd0, m_quad});
        chk(wrap_short == m_wrap, {tag, " wrap_short"}, {31'd0, wrap_short}, {31'd0, m_wrap});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] o, e;
        logic [7:0] b;
        bit ok;
        rst = 1'b1;
        ce_n = 1'b1;
        sck = 1'b0;
        sio_in = 4'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk(sio_oe == 4'b0000, "R1 sio_oe after reset", {28'd0, sio_oe}, 32'd0);
        chk_mode("R1");

        // R7 R8: one-lane write and reads
        do_write(8'h02, 1'b0, 1'b0, 24'h000010, 3, 32'hA1B2C300);
        do_read(8'h03, 1'b0, 1'b0, 0, 24'h000010, 3, "R7 read 03");
        do_read(8'h0B, 1'b0, 1'b0, 8, 24'h000011, 2, "R7 read 0B one-lane");
        do_write(8'h38, 1'b1, 1'b1, 24'h000100, 4, 32'h5A6B7C8D);
        do_read(8'hEB, 1'b1, 1'b1, 6, 24'h000100, 4, "R8 write 38 / R7 read EB");

        // R9: long wrap at a 1024-byte boundary, upper address bits kept
        do_write(8'h02, 1'b0, 1'b0, 24'h1003FE, 4, 32'h11223344);
        do_read(8'h03, 1'b0, 1'b0, 0, 24'h100000, 2, "R9 long wrap head");
        do_read(8'h03, 1'b0, 1'b0, 0, 24'h1003FE, 4, "R9 long wrap read");

        // R5 R9: short wrap
        simple_cmd(8'hC0);
        chk_mode("R5 toggle to 32");
        do_write(8'h02, 1'b0, 1'b0, 24'h00041E, 3, 32'hC1C2C300);
        do_read(8'h03, 1'b0, 1'b0, 0, 24'h000400, 1, "R9 short wrap head");
        do_read(8'h03, 1'b0, 1'b0, 0, 24'h00041E, 3, "R9 short wrap read");
        simple_cmd(8'hC0);
        chk_mode("R5 toggle to 1024");

        // R2: four-lane mode
        simple_cmd(8'h35);
        chk_mode("R2 enter four-lane");
        do_read(8'h0B, 1'b1, 1'b1, 4, 24'h000100, 2, "R7 four-lane 0B");
        do_read(8'hEB, 1'b1, 1'b1, 6, 24'h000010, 2, "R7 four-lane EB");
        do_write(8'h02, 1'b1, 1'b1, 24'h000200, 2, 32'hE7F80000);
        do_read(8'hEB, 1'b1, 1'b1, 6, 24'h000200, 2, "R8 four-lane 02");

        // R12: illegal in four-lane mode
        quiet_cmd(8'h9F, "R12 ID read ignored in four-lane");
        quiet_cmd(8'h03, "R12 slow read ignored in four-lane");
        chk_mode("R12 mode after illegal");

        // R3: disarm by an intervening command
        simple_cmd(8'hC0);
        simple_cmd(8'h66);
        simple_cmd(8'hC0);
        simple_cmd(8'h99);
        chk_mode("R3 disarmed reset");
        chk(quad_mode == 1'b1, "R3 quad kept", {31'd0, quad_mode}, 32'd1);

        // R3 R4: armed reset
        simple_cmd(8'hC0);
        simple_cmd(8'h66);
        simple_cmd(8'h99);
        chk_mode("R4 armed reset");
        chk(quad_mode == 1'b0 && wrap_short == 1'b0, "R4 reset state",
            {30'd0, quad_mode, wrap_short}, 32'd0);

        // R10: identification read
        ok = 1'b1;
        cs_begin();
        send_byte(8'h9F, 1'b0);
        model_cmd(8'h9F);
        send_addr(24'h000000, 1'b0);
        for (int k = 0; k < 3; k++) begin
            exp_q.push_back((k == 1) ? 8'h5D : 8'h0D);
            tag_q.push_back("R10 ID bytes");
            recv_byte(1'b0, b, ok);
            act_q.push_back(b);
        end
        cs_end();
        chk(ok, "R10 ID on one lane", {31'd0, ok}, 32'd1);

        // R2: exit four-lane
        simple_cmd(8'h35);
        simple_cmd(8'hF5);
        chk_mode("R2 exit four-lane");

        // R12: unknown opcode and F5 illegal in one-lane mode
        quiet_cmd(8'hAA, "R12 unknown opcode ignored");
        quiet_cmd(8'hF5, "R12 F5 ignored in one-lane");
        chk_mode("R12 mode after one-lane illegal");

        // R11: partial write byte discarded
        do_write(8'h02, 1'b0, 1'b0, 24'h000020, 2, 32'hAA110000);
        cs_begin();
        send_byte(8'h02, 1'b0);
        model_cmd(8'h02);
        send_addr(24'h000020, 1'b0);
        send_byte(8'h77, 1'b0);
        m_mem[11'h020] = 8'h77;
        for (int i = 0; i < 4; i++) step(4'h1, o, e);
        cs_end();
        do_read(8'h03, 1'b0, 1'b0, 0, 24'h000020, 2, "R11 partial byte dropped");

        // R11: lanes released after chip-select rises mid-read
        cs_begin();
        send_byte(8'h03, 1'b0);
        model_cmd(8'h03);
        send_addr(24'h000010, 1'b0);
        step(4'h0, o, e);
        chk(e == 4'b0010, "R11 driving before release", {28'd0, e}, 32'h2);
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        chk(sio_oe == 4'b0000, "R11 released after ce_n", {28'd0, sio_oe}, 32'h0);
        sck = 1'b0;
        repeat (3) @(negedge clk);

        repeat (10) @(negedge clk);
        chk(act_q.size() == 0 && exp_q.size() == 0, "R6 scoreboard drained",
            act_q.size(), exp_q.size());
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule